// File: doc/BRIEF.md
# Flash Geometry Discovery Engine

After reset this block finds out, with no software involved, how a 32-bit flash bus is laid out. The bus is two 16-bit flash devices side by side. The block switches the devices into their common-flash-interface query mode one byte at a time and checks the three-letter signature. It then fetches the command-algorithm code, the total size, the write-buffer size and the number of erase regions. From the region descriptors it builds a table of erase regions whose addresses add up from zero. Whatever else needs the flash layout reads the results from plain status pins, and reads the table through an index-addressed port.

The flash side is a simple synchronous port. One cycle with `fl_cmd_we` high writes a command word. One cycle with `fl_rd_en` high reads the word at `fl_addr`, and `fl_rdata` holds that word exactly `RD_LAT` cycles later. The block has no streaming data path. Every pin is a level or a strobe, and no handshake exists that could apply back-pressure. The table port is combinational: a table entry for any index appears in the same cycle.

Top module: `cfi_geometry_probe`

## Requirements
- R1: Every command write goes to word index 0x55. The 8-bit command is placed in both 16-bit halves of the 32-bit word, so the word is {8'h00,cmd,8'h00,cmd}. The command that enters query mode is 0x98 and the command that returns to array mode is 0xFF. No other command is issued.
- R2: Each query byte is fetched in the same way. The block writes the enter command in the cycle just before the read cycle. It takes only `fl_rdata[7:0]`, and takes it `RD_LAT` cycles after the read cycle. It then writes the exit command, so the flash is in array mode between bytes. Reads never occur back to back, and a successful probe makes exactly 7 + 4*count reads.
- R3: The bytes at query offsets 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59. At the first mismatch the block stops reading and raises `geo_fail`. `geo_valid` and `region_cnt` then stay 0, and every table entry reads zero.
- R4: `alg_id` is the byte at offset 0x13.
- R5: `total_bytes` is 2^(b+1), where b is the byte at 0x27. `wbuf_bytes` is 2^(w+1), where w is the byte at 0x2A. Either output is 0 if its power is 32 or more.
- R6: `region_cnt` is the byte at 0x2C, limited to `MAX_REGIONS` (32). The block reads only that many descriptors.
- R7: Descriptor i is the four bytes at 0x2D+4i, with the lowest-addressed byte as the least significant. The upper 16 bits times 512 give the block size, and the lower 16 bits plus 1 give the block count.
- R8: Region 0 has base 0. Each region's limit is its base plus block size times block count, taken modulo 2^32. Each following base equals the previous limit.
- R9: `geo_valid` rises only after the last table entry is stored, or right after the count is read if the count is zero. `geo_valid` and `geo_fail` are never high together, each stays high until reset, and no flash access follows either one.
- R10: Table indices at or above `region_cnt` read all zero.
- R11: While reset is held, every status output, table output and flash strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the probe starts when it is released |
| fl_cmd_we | output | 1 | Command write strobe |
| fl_rd_en | output | 1 | Read strobe |
| fl_addr | output | FA_W | Word index for the command or read |
| fl_wdata | output | 32 | Command word |
| fl_rdata | input | 32 | Read word, valid RD_LAT cycles after the read strobe |
| geo_valid | output | 1 | Geometry table complete |
| geo_fail | output | 1 | Signature mismatch |
| alg_id | output | 8 | Command-algorithm code |
| total_bytes | output | 32 | Total device bytes |
| wbuf_bytes | output | 32 | Write-buffer bytes |
| region_cnt | output | CNT_W | Number of erase regions after the limit is applied |
| rgn_idx | input | IDX_W | Table index |
| rgn_base | output | 32 | First byte of the indexed region |
| rgn_limit | output | 32 | One past the last byte of the indexed region |
| rgn_bsize | output | 32 | Block size of the indexed region |
| rgn_bcnt | output | 32 | Block count of the indexed region |

## Verification
The assertions assume that the flash answers only the reads the block makes, always after exactly `RD_LAT` cycles, and that no other master writes commands while the probe runs. The bench memory model meets these assumptions. It is a fixed `RD_LAT`-stage pipeline that serves query bytes only while the enter command is in effect and returns a non-signature pattern in array mode. Each probe is started by a fresh reset, so reads and commands never overlap from one run to the next. The model also counts any command word that is not correctly mirrored and any read issued outside query mode, and the bench checks both counts.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned CMD_WORD_IDX = 'h55;
  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] SIG_Q = 8'h51;
  localparam logic [7:0] SIG_R = 8'h52;
  localparam logic [7:0] SIG_Y = 8'h59;
  localparam int unsigned OFF_SIG0 = 'h10;
  localparam int unsigned OFF_ALG  = 'h13;
  localparam int unsigned OFF_TSZ  = 'h27;
  localparam int unsigned OFF_WBS  = 'h2A;
  localparam int unsigned OFF_NRG  = 'h2C;
  localparam int unsigned OFF_DESC = 'h2D;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] limit;
    logic [AW-1:0] bsize;
    logic [AW-1:0] bcnt;
  } region_t;

  typedef enum logic [3:0] {
    S_START, S_SIG0, S_SIG1, S_SIG2, S_ALG, S_TSZ, S_WBS, S_NRG, S_REG, S_PASS, S_FAIL
  } seq_e;

  typedef enum logic [2:0] {B_IDLE, B_ENTER, B_READ, B_WAIT, B_EXIT} rdr_e;

  function automatic logic [DW-1:0] mirror(input logic [7:0] cmd);
    return {8'h00, cmd, 8'h00, cmd};
  endfunction
endpackage

// File: rtl/cfi_query_reader.sv
module cfi_query_reader
  import cfi_probe_pkg::*;
#(
  parameter int unsigned FA_W   = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FA_W-1:0] off,
  output logic            done,
  output logic [7:0]      qbyte,
  output logic            fl_cmd_we,
  output logic            fl_rd_en,
  output logic [FA_W-1:0] fl_addr,
  output logic [DW-1:0]   fl_wdata,
  input  logic [DW-1:0]   fl_rdata
);
  localparam int unsigned CW = $clog2(RD_LAT + 1);

  rdr_e            st;
  logic [FA_W-1:0] off_q;
  logic [CW-1:0]   cnt;
  logic [7:0]      byte_q;
  logic            unused_hi;

  assign unused_hi = ^fl_rdata[DW-1:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      off_q  <= '0;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      case (st)
        B_IDLE:  if (start) begin
                   off_q <= off;
                   st    <= B_ENTER;
                 end
        B_ENTER: st <= B_READ;
        B_READ:  begin
                   cnt <= CW'(1);
                   st  <= B_WAIT;
                 end
        B_WAIT:  if (cnt == CW'(RD_LAT)) begin
                   byte_q <= fl_rdata[7:0];
                   st     <= B_EXIT;
                 end else begin
                   cnt <= cnt + CW'(1);
                 end
        B_EXIT:  st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_cmd_we = (st == B_ENTER) || (st == B_EXIT);
    fl_rd_en  = (st == B_READ);
    fl_addr   = fl_rd_en ? off_q : FA_W'(CMD_WORD_IDX);
    fl_wdata  = fl_cmd_we ? mirror((st == B_EXIT) ? CMD_ARRAY : CMD_QUERY) : '0;
  end

  assign done  = (st == B_EXIT);
  assign qbyte = byte_q;
endmodule

// File: rtl/cfi_region_table.sv
module cfi_region_table
  import cfi_probe_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  region_t          wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output region_t          rd_ent
);
  region_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[g] <= '0;
      else if (wr_en && (int'(wr_idx) == g))
        ent_q[g] <= wr_ent;
    end
  end

  always_comb begin
    rd_ent = '0;
    if (int'(rd_idx) < DEPTH)
      rd_ent = ent_q[rd_idx];
  end
endmodule

// File: rtl/cfi_geometry_probe.sv
module cfi_geometry_probe
  import cfi_probe_pkg::*;
#(
  parameter int unsigned FA_W        = 16,
  parameter int unsigned MAX_REGIONS = 32,
  parameter int unsigned RD_LAT      = 2,
  localparam int unsigned IDX_W      = $clog2(MAX_REGIONS),
  localparam int unsigned CNT_W      = $clog2(MAX_REGIONS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             fl_cmd_we,
  output logic             fl_rd_en,
  output logic [FA_W-1:0]  fl_addr,
  output logic [DW-1:0]    fl_wdata,
  input  logic [DW-1:0]    fl_rdata,
  output logic             geo_valid,
  output logic             geo_fail,
  output logic [7:0]       alg_id,
  output logic [AW-1:0]    total_bytes,
  output logic [AW-1:0]    wbuf_bytes,
  output logic [CNT_W-1:0] region_cnt,
  input  logic [IDX_W-1:0] rgn_idx,
  output logic [AW-1:0]    rgn_base,
  output logic [AW-1:0]    rgn_limit,
  output logic [AW-1:0]    rgn_bsize,
  output logic [AW-1:0]    rgn_bcnt
);
  seq_e             st;
  logic             pend;
  logic             q_start, q_done;
  logic [FA_W-1:0]  q_off;
  logic [7:0]       q_byte;
  logic [7:0]       alg_q;
  logic [AW-1:0]    tot_q, wbs_q, cursor;
  logic [CNT_W-1:0] nreg_q, nr_clamp;
  logic [IDX_W-1:0] ridx;
  logic [1:0]       k;
  logic [23:0]      desc_lo;
  logic [31:0]      desc_full;
  logic [AW-1:0]    span;
  logic             tbl_we, last_rgn;
  region_t          ent_w, ent_r;

  function automatic logic [AW-1:0] pow2(input logic [7:0] e);
    logic [8:0] s;
    s = {1'b0, e} + 9'd1;
    return (s < 9'(AW)) ? (AW'(1) << s) : '0;
  endfunction

  cfi_query_reader #(.FA_W(FA_W), .RD_LAT(RD_LAT)) u_reader (
    .clk, .rst_n, .start(q_start), .off(q_off), .done(q_done), .qbyte(q_byte),
    .fl_cmd_we, .fl_rd_en, .fl_addr, .fl_wdata, .fl_rdata
  );

  cfi_region_table #(.DEPTH(MAX_REGIONS), .IDX_W(IDX_W)) u_table (
    .clk, .rst_n, .wr_en(tbl_we), .wr_idx(ridx), .wr_ent(ent_w),
    .rd_idx(rgn_idx), .rd_ent(ent_r)
  );

  always_comb begin
    q_start = !pend && (st inside {S_SIG0, S_SIG1, S_SIG2, S_ALG, S_TSZ, S_WBS, S_NRG, S_REG});
    case (st)
      S_SIG1:  q_off = FA_W'(OFF_SIG0 + 1);
      S_SIG2:  q_off = FA_W'(OFF_SIG0 + 2);
      S_ALG:   q_off = FA_W'(OFF_ALG);
      S_TSZ:   q_off = FA_W'(OFF_TSZ);
      S_WBS:   q_off = FA_W'(OFF_WBS);
      S_NRG:   q_off = FA_W'(OFF_NRG);
      S_REG:   q_off = FA_W'(OFF_DESC) + FA_W'({ridx, k});
      default: q_off = FA_W'(OFF_SIG0);
    endcase
  end

  always_comb begin
    desc_full   = {q_byte, desc_lo};
    ent_w.base  = cursor;
    ent_w.bsize = AW'(desc_full[31:16]) << 9;
    ent_w.bcnt  = AW'(desc_full[15:0]) + AW'(1);
    span        = ent_w.bsize * ent_w.bcnt;
    ent_w.limit = cursor + span;
    tbl_we      = (st == S_REG) && pend && q_done && (k == 2'd3);
    last_rgn    = (CNT_W'(ridx) + CNT_W'(1)) == nreg_q;
    nr_clamp    = (int'(q_byte) > MAX_REGIONS) ? CNT_W'(MAX_REGIONS) : CNT_W'(q_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_START;  pend <= 1'b0;  alg_q <= '0;
      tot_q <= '0;    wbs_q <= '0;   nreg_q <= '0;
      ridx <= '0;     k <= '0;       desc_lo <= '0;  cursor <= '0;
    end else begin
      if (st == S_START) st <= S_SIG0;
      if (q_start) pend <= 1'b1;
      if (pend && q_done) begin
        pend <= 1'b0;
        case (st)
          S_SIG0: st <= (q_byte == SIG_Q) ? S_SIG1 : S_FAIL;
          S_SIG1: st <= (q_byte == SIG_R) ? S_SIG2 : S_FAIL;
          S_SIG2: st <= (q_byte == SIG_Y) ? S_ALG  : S_FAIL;
          S_ALG:  begin alg_q <= q_byte;       st <= S_TSZ; end
          S_TSZ:  begin tot_q <= pow2(q_byte); st <= S_WBS; end
          S_WBS:  begin wbs_q <= pow2(q_byte); st <= S_NRG; end
          S_NRG:  begin
                    nreg_q <= nr_clamp;
                    ridx <= '0;  k <= '0;  cursor <= '0;
                    st <= (nr_clamp == '0) ? S_PASS : S_REG;
                  end
          S_REG:  begin
                    case (k)
                      2'd0: desc_lo[7:0]   <= q_byte;
                      2'd1: desc_lo[15:8]  <= q_byte;
                      2'd2: desc_lo[23:16] <= q_byte;
                      default: ;
                    endcase
                    if (k == 2'd3) begin
                      k      <= '0;
                      cursor <= ent_w.limit;
                      if (last_rgn) st <= S_PASS;
                      else          ridx <= ridx + IDX_W'(1);
                    end else begin
                      k <= k + 2'd1;
                    end
                  end
          default: ;
        endcase
      end
    end
  end

  assign geo_valid   = (st == S_PASS);
  assign geo_fail    = (st == S_FAIL);
  assign alg_id      = alg_q;
  assign total_bytes = tot_q;
  assign wbuf_bytes  = wbs_q;
  assign region_cnt  = nreg_q;
  assign rgn_base    = ent_r.base;
  assign rgn_limit   = ent_r.limit;
  assign rgn_bsize   = ent_r.bsize;
  assign rgn_bcnt    = ent_r.bcnt;
endmodule

// File: rtl/cfi_geometry_probe_chk.sv
module cfi_geometry_probe_chk #(
  parameter int unsigned FA_W        = 16,
  parameter int unsigned MAX_REGIONS = 32,
  parameter int unsigned CNT_W       = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fl_cmd_we,
  input logic             fl_rd_en,
  input logic [FA_W-1:0]  fl_addr,
  input logic [31:0]      fl_wdata,
  input logic             geo_valid,
  input logic             geo_fail,
  input logic [CNT_W-1:0] region_cnt
);
  // R1
  cmd_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_we |-> (fl_addr == FA_W'('h55)) && (fl_wdata[31:16] == fl_wdata[15:0])
                  && (fl_wdata[15:8] == 8'h00)
                  && ((fl_wdata[7:0] == 8'h98) || (fl_wdata[7:0] == 8'hFF)));
  // R2
  enter_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_en |-> $past(fl_cmd_we) && ($past(fl_wdata[7:0]) == 8'h98));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_rd_en && fl_cmd_we));
  // R2
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_en |=> !fl_rd_en);
  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(geo_valid && geo_fail));
  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    geo_valid |=> geo_valid);
  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    geo_fail |=> geo_fail);
  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (geo_valid || geo_fail) |-> !fl_cmd_we && !fl_rd_en);
  // R6
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(region_cnt) <= MAX_REGIONS);
  // R3
  fail_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    geo_fail |-> (region_cnt == '0));
endmodule

bind cfi_geometry_probe cfi_geometry_probe_chk #(
  .FA_W(FA_W), .MAX_REGIONS(MAX_REGIONS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_cmd_we(fl_cmd_we), .fl_rd_en(fl_rd_en),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata), .geo_valid(geo_valid),
  .geo_fail(geo_fail), .region_cnt(region_cnt)
);

// File: tb/test_cfi_geometry_probe.sv
module test_cfi_geometry_probe;
  localparam int FA_W = 16;
  localparam int MAXR = 32;
  localparam int RD_LAT = 2;
  localparam int IDX_W = 5;
  localparam int CNT_W = 6;

  typedef struct packed {
    logic [1:0]  bad;
    logic [7:0]  alg, sz, wb, nr;
    logic [31:0] d0, d1;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 8'h01, 8'd24, 8'd5,  8'd2, 32'h0002_0003, 32'h0100_003E},
    '{2'd0, 8'h02, 8'd22, 8'd4,  8'd1, 32'h0080_007F, 32'h0000_0000},
    '{2'd0, 8'h03, 8'd31, 8'd0,  8'd3, 32'h0001_0000, 32'h0004_0001},
    '{2'd2, 8'h01, 8'd20, 8'd5,  8'd2, 32'h0002_0003, 32'h0004_0001},
    '{2'd0, 8'h07, 8'd30, 8'd31, 8'd0, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             fl_cmd_we, fl_rd_en, geo_valid, geo_fail;
  logic [FA_W-1:0]  fl_addr;
  logic [31:0]      fl_wdata, fl_rdata;
  logic [7:0]       alg_id;
  logic [31:0]      total_bytes, wbuf_bytes, rgn_base, rgn_limit, rgn_bsize, rgn_bcnt;
  logic [CNT_W-1:0] region_cnt;
  logic [IDX_W-1:0] rgn_idx = '0;

  cfi_geometry_probe #(.FA_W(FA_W), .MAX_REGIONS(MAXR), .RD_LAT(RD_LAT)) i_cfi_geometry_probe (
    .clk, .rst_n, .fl_cmd_we, .fl_rd_en, .fl_addr, .fl_wdata, .fl_rdata,
    .geo_valid, .geo_fail, .alg_id, .total_bytes, .wbuf_bytes, .region_cnt,
    .rgn_idx, .rgn_base, .rgn_limit, .rgn_bsize, .rgn_bcnt
  );

  // flash image configuration
  int          cfg_bad;
  logic [7:0]  cfg_alg, cfg_sz, cfg_wb, cfg_nr;
  logic [31:0] cfg_d0, cfg_d1;

  function automatic logic [31:0] desc(input int i);
    if (i == 0) return cfg_d0;
    if (i == 1) return cfg_d1;
    return {16'(i + 1), 16'(i)};
  endfunction

  function automatic logic [7:0] qb(input logic [FA_W-1:0] off);
    logic [31:0] d;
    case (int'(off))
      'h10: return (cfg_bad == 1) ? 8'h00 : 8'h51;
      'h11: return (cfg_bad == 2) ? 8'h00 : 8'h52;
      'h12: return (cfg_bad == 3) ? 8'h00 : 8'h59;
      'h13: return cfg_alg;
      'h27: return cfg_sz;
      'h2A: return cfg_wb;
      'h2C: return cfg_nr;
      default: begin
        if (int'(off) < 'h2D) return 8'h00;
        d = desc((int'(off) - 'h2D) / 4);
        return d[8*((int'(off) - 'h2D) % 4) +: 8];
      end
    endcase
  endfunction

  // flash memory model: fixed-latency pipeline, query data only in query mode
  logic        qmode;
  logic [31:0] pipe [RD_LAT];
  int          bad_cmd, stray_rd, n_rd;
  assign fl_rdata = pipe[RD_LAT-1];

  always @(posedge clk) begin
    if (!rst_n) begin
      qmode <= 1'b0; bad_cmd <= 0; stray_rd <= 0; n_rd <= 0;
      for (int i = 0; i < RD_LAT; i++) pipe[i] <= '0;
    end else begin
      if (fl_cmd_we) begin
        if (fl_addr == 16'h55 && fl_wdata == 32'h0098_0098) qmode <= 1'b1;
        else if (fl_addr == 16'h55 && fl_wdata == 32'h00FF_00FF) qmode <= 1'b0;
        else bad_cmd <= bad_cmd + 1;
      end
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
      pipe[0] <= 32'h0;
      if (fl_rd_en) begin
        n_rd <= n_rd + 1;
        if (!qmode) stray_rd <= stray_rd + 1;
        pipe[0] <= qmode ? {8'h00, qb(fl_addr), 8'h00, qb(fl_addr)} : 32'hA5A5_5A5A;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] epow(input logic [7:0] e);
    return (int'(e) + 1 < 32) ? (32'd1 << (int'(e) + 1)) : 32'd0;
  endfunction

  task automatic run_cfg(input string tag);
    int exp_cnt, exp_rd, waited, rd_done;
    logic [31:0] base, bs, bc, dsc;
    exp_cnt = (int'(cfg_nr) > MAXR) ? MAXR : int'(cfg_nr);
    if (cfg_bad != 0) exp_cnt = 0;
    exp_rd = (cfg_bad != 0) ? cfg_bad : 7 + 4 * exp_cnt;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    waited = 0;
    while (!(geo_valid || geo_fail) && waited < 4000) begin @(negedge clk); waited++; end
    $display("run %s done after %0d cycles", tag, waited);
    if (cfg_bad != 0) begin
      chk("R3", "fail flag", geo_fail, 1);
      chk("R3", "valid low", geo_valid, 0);
      chk("R3", "count zero", region_cnt, 0);
      rgn_idx = '0; #1;
      chk("R3", "entry0 empty", {rgn_base, rgn_limit, rgn_bsize, rgn_bcnt}, 0);
      chk("R3", "stops at mismatch (reads)", n_rd, exp_rd);
    end else begin
      chk("R9", "valid flag", geo_valid, 1);
      chk("R9", "fail low", geo_fail, 0);
      chk("R4", "alg id", alg_id, cfg_alg);
      chk("R5", "total bytes", total_bytes, epow(cfg_sz));
      chk("R5", "wbuf bytes", wbuf_bytes, epow(cfg_wb));
      chk("R6", "region count", region_cnt, exp_cnt);
      chk("R2", "read count", n_rd, exp_rd);
      base = 0;
      for (int i = 0; i < exp_cnt; i++) begin
        dsc = desc(i);
        bs = {16'h0, dsc[31:16]} << 9;
        bc = {16'h0, dsc[15:0]} + 1;
        rgn_idx = IDX_W'(i); #1;
        chk("R7", "block size", rgn_bsize, bs);
        chk("R7", "block count", rgn_bcnt, bc);
        chk("R8", "base", rgn_base, base);
        base = base + bs * bc;
        chk("R8", "limit", rgn_limit, base);
      end
      if (exp_cnt < MAXR) begin
        rgn_idx = IDX_W'(exp_cnt); #1;
        chk("R10", "entry past count", {rgn_base, rgn_limit, rgn_bsize, rgn_bcnt}, 0);
      end
    end
    chk("R1", "malformed commands", bad_cmd, 0);
    chk("R2", "reads outside query mode", stray_rd, 0);
    chk("R2", "left in array mode", qmode, 0);
    rd_done = n_rd;
    repeat (16) @(negedge clk);
    chk("R9", "no reads after done", n_rd, rd_done);
    chk("R9", "done state held", {geo_valid, geo_fail}, (cfg_bad != 0) ? 2'b01 : 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_bad = 0; cfg_alg = 8'h01; cfg_sz = 8'd20; cfg_wb = 8'd5; cfg_nr = 8'd1;
    cfg_d0 = 32'h0002_0003; cfg_d1 = 32'h0;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "status during reset",
        {geo_valid, geo_fail, alg_id, total_bytes, wbuf_bytes, region_cnt}, 0);
    chk("R11", "strobes during reset", {fl_cmd_we, fl_rd_en}, 0);
    chk("R11", "table during reset", {rgn_base, rgn_limit, rgn_bsize, rgn_bcnt}, 0);

    for (int v = 0; v < 5; v++) begin
      cfg_bad = int'(VECS[v].bad); cfg_alg = VECS[v].alg; cfg_sz = VECS[v].sz;
      cfg_wb = VECS[v].wb; cfg_nr = VECS[v].nr; cfg_d0 = VECS[v].d0; cfg_d1 = VECS[v].d1;
      run_cfg($sformatf("vec%0d", v));
    end

    // R6 clamp: 40 regions reported, only 32 read
    cfg_bad = 0; cfg_alg = 8'h01; cfg_sz = 8'd25; cfg_wb = 8'd6; cfg_nr = 8'd40;
    cfg_d0 = 32'h0040_0003; cfg_d1 = 32'h0200_00FE;
    run_cfg("clamp40");
    // R6 exactly 32 regions
    cfg_nr = 8'd32;
    run_cfg("exact32");
    // R3 first and last signature byte wrong
    cfg_bad = 1; run_cfg("badQ");
    cfg_bad = 3; run_cfg("badY");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule